// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block breaks one multi-register load or store into a stream of simple micro-operations for a pipeline that runs only single-register memory accesses and immediate arithmetic. It takes a 16-bit register list, a base register index and five mode bits: load/store, up/down, pre/post indexing, writeback, and a user-bank/exception-return bit. It then emits one micro-op per cycle over a valid/ready handshake.

The first micro-op copies the base register into a temporary register. Every memory micro-op then addresses relative to that temporary, so a base that also appears in the list can be loaded without disturbing the remaining addresses. One memory micro-op follows for each set bit of the list, taken in ascending register order. When writeback is requested, a closing add or subtract updates the base register.

When the user/exception bit is set, the register indices are redirected to the user bank if the program counter (register 15) is absent from the list. A load of the program counter under that bit becomes an exception-return load, which also restores the status register. Each micro-op carries a last flag so that the consumer can tell where the instruction ends.

Top module: `lsm_uop_seq`

## Requirements
- R1: `in_ready` is high exactly when no instruction is in progress, and an instruction is taken when `in_valid` and `in_ready` are both high at a clock edge. While `out_valid` is high and `out_ready` is low, every micro-op output holds its value.
- R2: The first micro-op after acceptance is a copy. It has opcode 0 (add-immediate), `out_rd` = 31 (the temporary), `out_rb` = the base index, immediate 0 and `out_up` = 1.
- R3: One memory micro-op is emitted per set bit of the list, in ascending register order, each with `out_rb` = 31. Without the user-bank redirection, `out_rd` is the register index.
- R4: In up mode (`out_up` = 1, address = temporary + immediate), the first immediate is 0, or 4 with pre-indexing, and each following transfer adds 4.
- R5: In down mode (`out_up` = 0, address = temporary − immediate), the first immediate is 4·n − 4, or 4·n with pre-indexing, where n is the number of set bits. Each following transfer subtracts 4.
- R6: Memory micro-ops use opcode 2 for a load and opcode 4 for a store.
- R7: When the user bit is set and list bit 15 is clear, every transfer's `out_rd` is 16 + register index.
- R8: When the user bit is set and the operation is a load, the transfer of register 15 uses opcode 3 (exception-return load) with `out_rd` = 15.
- R9: With writeback, a final micro-op is emitted with `out_rd` = `out_rb` = the base index and immediate 4·n. Its opcode is 0 (add) in up mode and 1 (subtract) in down mode.
- R10: Exactly one micro-op per instruction has `out_last` = 1, and it is the final one. After that micro-op is taken, `out_valid` falls.
- R11: An empty list produces only the copy micro-op, followed by the writeback micro-op if writeback is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted |
| in_mask | input | 16 | Register list |
| in_base | input | 4 | Base register index |
| in_load | input | 1 | 1 = load, 0 = store |
| in_up | input | 1 | 1 = ascending addresses |
| in_pre | input | 1 | Pre-indexing |
| in_wb | input | 1 | Base writeback |
| in_user | input | 1 | User bank / exception return |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Consumer takes micro-op |
| out_op | output | 3 | Opcode: 0 add-imm, 1 sub-imm, 2 load, 3 return load, 4 store |
| out_rd | output | 5 | Data/destination register (16–30 user bank, 31 temporary) |
| out_rb | output | 5 | Base register for the micro-op |
| out_imm | output | 7 | Immediate offset |
| out_up | output | 1 | Immediate added (1) or subtracted (0) |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
The assertions check the handshake on every cycle: outputs hold while stalled, no instruction is taken while busy, a copy always comes first, memory micro-ops always use the temporary base, immediates stay word-aligned, a return load always targets register 15, and `out_valid` falls after the last flag. Only the bench's scenarios can show the exact visiting order, the offset sequences of the four indexing modes, the user-bank redirection, the writeback amount and the empty-list shortening. These are compared against a bench model over directed corner lists and random instructions with random consumer stalls.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int unsigned LIST_W     = 16;
    localparam int unsigned IDX_W      = $clog2(LIST_W);
    localparam int unsigned PIDX_W     = IDX_W + 1;
    localparam int unsigned CNT_W      = $clog2(LIST_W + 1);
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned IMM_W      = $clog2(LIST_W * WORD_BYTES) + 1;
    localparam int unsigned OP_W       = 3;

    localparam logic [PIDX_W-1:0] TMP_IDX = '1;
    localparam logic [IDX_W-1:0]  PC_IDX  = IDX_W'(LIST_W - 1);

    typedef enum logic [OP_W-1:0] {
        OP_ADDI     = 3'd0,
        OP_SUBI     = 3'd1,
        OP_LOAD     = 3'd2,
        OP_LOAD_RET = 3'd3,
        OP_STORE    = 3'd4
    } uop_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_XFER,
        ST_WB
    } seq_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] base;
        logic             is_load;
        logic             up;
        logic             wb;
        logic             usr;
        logic             pc_listed;
    } xfer_cmd_t;

    typedef struct packed {
        uop_op_e           op;
        logic [PIDX_W-1:0] rd;
        logic [PIDX_W-1:0] rb;
        logic [IMM_W-1:0]  imm;
        logic              up;
        logic              last;
    } uop_t;

    function automatic logic [CNT_W-1:0] count_ones(input logic [LIST_W-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < int'(LIST_W); i++) begin
            c = c + CNT_W'(v[i]);
        end
        return c;
    endfunction

    function automatic logic [IMM_W-1:0] span_bytes(input logic [CNT_W-1:0] cnt);
        return IMM_W'(cnt) * IMM_W'(WORD_BYTES);
    endfunction

    function automatic logic [IMM_W-1:0] start_offset(input logic [CNT_W-1:0] cnt,
                                                      input logic up,
                                                      input logic pre);
        logic [IMM_W-1:0] step;
        step = IMM_W'(WORD_BYTES);
        if (up) begin
            return pre ? step : '0;
        end
        return pre ? span_bytes(cnt) : span_bytes(cnt) - step;
    endfunction

endpackage

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int unsigned W   = 16,
    parameter int unsigned IW  = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = int'(W) - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lsm_uop_form.sv
module lsm_uop_form
    import lsm_pkg::*;
(
    input  seq_state_e       state,
    input  xfer_cmd_t        cmd,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IMM_W-1:0] offset,
    input  logic [CNT_W-1:0] cnt,
    input  logic             list_empty,
    input  logic             final_xfer,
    output uop_t             uop
);
    logic is_ret;
    logic remap;

    assign is_ret = cmd.usr && cmd.is_load && (cur_idx == PC_IDX);
    assign remap  = cmd.usr && !cmd.pc_listed;

    always_comb begin
        uop = '0;
        unique case (state)
            ST_COPY: begin
                uop.op   = OP_ADDI;
                uop.rd   = TMP_IDX;
                uop.rb   = {1'b0, cmd.base};
                uop.imm  = '0;
                uop.up   = 1'b1;
                uop.last = list_empty && !cmd.wb;
            end
            ST_XFER: begin
                if (cmd.is_load) begin
                    uop.op = is_ret ? OP_LOAD_RET : OP_LOAD;
                end else begin
                    uop.op = OP_STORE;
                end
                uop.rd   = {remap, cur_idx};
                uop.rb   = TMP_IDX;
                uop.imm  = offset;
                uop.up   = cmd.up;
                uop.last = final_xfer && !cmd.wb;
            end
            ST_WB: begin
                uop.op   = cmd.up ? OP_ADDI : OP_SUBI;
                uop.rd   = {1'b0, cmd.base};
                uop.rb   = {1'b0, cmd.base};
                uop.imm  = span_bytes(cnt);
                uop.up   = cmd.up;
                uop.last = 1'b1;
            end
            default: uop = '0;
        endcase
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LIST_W-1:0]   in_mask,
    input  logic [IDX_W-1:0]    in_base,
    input  logic                in_load,
    input  logic                in_up,
    input  logic                in_pre,
    input  logic                in_wb,
    input  logic                in_user,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [OP_W-1:0]     out_op,
    output logic [PIDX_W-1:0]   out_rd,
    output logic [PIDX_W-1:0]   out_rb,
    output logic [IMM_W-1:0]    out_imm,
    output logic                out_up,
    output logic                out_last
);
    seq_state_e        state;
    xfer_cmd_t         cmd;
    logic [LIST_W-1:0] work;
    logic [LIST_W-1:0] work_next;
    logic [IMM_W-1:0]  offset;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  cur_idx;
    logic              fire;
    uop_t              uop;

    lsm_lowbit #(.W(LIST_W), .IW(IDX_W)) u_scan (
        .vec (work),
        .idx (cur_idx)
    );

    assign work_next = work & ~(LIST_W'(1) << cur_idx);

    lsm_uop_form u_form (
        .state      (state),
        .cmd        (cmd),
        .cur_idx    (cur_idx),
        .offset     (offset),
        .cnt        (cnt),
        .list_empty (work == '0),
        .final_xfer (work_next == '0),
        .uop        (uop)
    );

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state != ST_IDLE);
    assign fire      = out_valid && out_ready;

    assign out_op   = uop.op;
    assign out_rd   = uop.rd;
    assign out_rb   = uop.rb;
    assign out_imm  = uop.imm;
    assign out_up   = uop.up;
    assign out_last = uop.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cmd    <= '0;
            work   <= '0;
            offset <= '0;
            cnt    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        cmd.base      <= in_base;
                        cmd.is_load   <= in_load;
                        cmd.up        <= in_up;
                        cmd.wb        <= in_wb;
                        cmd.usr       <= in_user;
                        cmd.pc_listed <= in_mask[PC_IDX];
                        work          <= in_mask;
                        cnt           <= count_ones(in_mask);
                        offset        <= start_offset(count_ones(in_mask), in_up, in_pre);
                        state         <= ST_COPY;
                    end
                end
                ST_COPY: begin
                    if (fire) begin
                        if (work != '0) begin
                            state <= ST_XFER;
                        end else begin
                            state <= cmd.wb ? ST_WB : ST_IDLE;
                        end
                    end
                end
                ST_XFER: begin
                    if (fire) begin
                        work   <= work_next;
                        offset <= cmd.up ? offset + IMM_W'(WORD_BYTES)
                                         : offset - IMM_W'(WORD_BYTES);
                        if (work_next == '0) begin
                            state <= cmd.wb ? ST_WB : ST_IDLE;
                        end
                    end
                end
                ST_WB: begin
                    if (fire) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk
    import lsm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OP_W-1:0]   out_op,
    input logic [PIDX_W-1:0] out_rd,
    input logic [PIDX_W-1:0] out_rb,
    input logic [IMM_W-1:0]  out_imm,
    input logic              out_up,
    input logic              out_last
);
    logic is_mem;
    assign is_mem = (out_op == 3'd2) || (out_op == 3'd3) || (out_op == 3'd4);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_rd)
            && $stable(out_rb) && $stable(out_imm) && $stable(out_up) && $stable(out_last)); // R1

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R1

    AST_COPY_FIRST: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && out_op == 3'd0 && out_rd == TMP_IDX && out_imm == '0); // R2

    AST_MEM_TMP_BASE: assert property (@(posedge clk) disable iff (rst)
        out_valid && is_mem |-> out_rb == TMP_IDX); // R3

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_imm[1:0] == 2'b00); // R4

    AST_RET_TARGETS_PC: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_op == 3'd3 |-> out_rd == {1'b0, PC_IDX}); // R8

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid); // R10
endmodule

bind lsm_uop_seq lsm_uop_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_op    (out_op),
    .out_rd    (out_rd),
    .out_rb    (out_rb),
    .out_imm   (out_imm),
    .out_up    (out_up),
    .out_last  (out_last)
);

// File: tb/sim_lsm_uop_seq.sv
module sim_lsm_uop_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_mask;
    logic [3:0]  in_base;
    logic        in_load, in_up, in_pre, in_wb, in_user;
    logic        out_valid;
    logic        out_ready;
    logic [2:0]  out_op;
    logic [4:0]  out_rd, out_rb;
    logic [6:0]  out_imm;
    logic        out_up, out_last;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int    e_n;
    int    e_op  [0:17];
    int    e_rd  [0:17];
    int    e_rb  [0:17];
    int    e_imm [0:17];
    int    e_up  [0:17];
    int    e_last[0:17];
    string t_op  [0:17];
    string t_rd  [0:17];
    string t_imm [0:17];

    always #5 clk = ~clk;

    lsm_uop_seq u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mask(in_mask), .in_base(in_base), .in_load(in_load), .in_up(in_up),
        .in_pre(in_pre), .in_wb(in_wb), .in_user(in_user),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_rd(out_rd), .out_rb(out_rb), .out_imm(out_imm),
        .out_up(out_up), .out_last(out_last)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic build(input logic [15:0] m, input int base, input bit ld,
                         input bit up, input bit pre, input bit wb, input bit usr);
        int n, off, k;
        bit remap;
        n = $countones(m);
        remap = usr && !m[15];
        e_op[0] = 0; e_rd[0] = 31; e_rb[0] = base; e_imm[0] = 0; e_up[0] = 1;
        t_op[0] = "R2"; t_rd[0] = "R2"; t_imm[0] = "R2";
        k = 1;
        if (up) off = pre ? 4 : 0;
        else    off = pre ? 4 * n : 4 * n - 4;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                if (ld) e_op[k] = (usr && i == 15) ? 3 : 2;
                else    e_op[k] = 4;
                t_op[k]  = (usr && ld && i == 15) ? "R8" : "R6";
                e_rd[k]  = remap ? 16 + i : i;
                t_rd[k]  = remap ? "R7" : "R3";
                e_rb[k]  = 31;
                e_imm[k] = off;
                t_imm[k] = up ? "R4" : "R5";
                e_up[k]  = up;
                off = up ? off + 4 : off - 4;
                k++;
            end
        end
        if (wb) begin
            e_op[k] = up ? 0 : 1; e_rd[k] = base; e_rb[k] = base;
            e_imm[k] = 4 * n; e_up[k] = up;
            t_op[k] = "R9"; t_rd[k] = "R9"; t_imm[k] = "R9";
            k++;
        end
        for (int j = 0; j < k; j++) e_last[j] = (j == k - 1) ? 1 : 0;
        e_n = k;
    endtask

    task automatic run_one(input logic [15:0] m, input int base, input bit ld,
                           input bit up, input bit pre, input bit wb, input bit usr,
                           input int stall_pct);
        int idx;
        build(m, base, ld, up, pre, wb, usr);
        @(negedge clk);
        chk("R1", "in_ready when idle", int'(in_ready), 1);
        in_valid = 1'b1; in_mask = m; in_base = 4'(base); in_load = ld;
        in_up = up; in_pre = pre; in_wb = wb; in_user = usr;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_mask = 16'($urandom);
        idx = 0;
        while (idx < e_n) begin
            out_ready = (($urandom % 100) >= stall_pct);
            chk("R1", "out_valid while busy", int'(out_valid), 1);
            if (out_ready && out_valid) begin
                chk(t_op[idx],  "op",  int'(out_op),  e_op[idx]);
                chk(t_rd[idx],  "rd",  int'(out_rd),  e_rd[idx]);
                chk(idx == 0 ? "R2" : "R3", "rb", int'(out_rb), e_rb[idx]);
                chk(t_imm[idx], "imm", int'(out_imm), e_imm[idx]);
                chk(t_imm[idx], "up",  int'(out_up),  e_up[idx]);
                chk("R10", "last", int'(out_last), e_last[idx]);
                idx++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(m == 16'h0 ? "R11" : "R10", "valid after final", int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        in_mask = '0; in_base = '0; in_load = 0; in_up = 0; in_pre = 0; in_wb = 0; in_user = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset out_valid", int'(out_valid), 0);
        chk("R1", "reset in_ready", int'(in_ready), 1);

        // Directed corners
        run_one(16'h0000, 3, 1, 1, 0, 0, 0, 0);   // R11 copy only
        run_one(16'h0000, 5, 0, 0, 1, 1, 0, 30);  // R11 copy + subtract writeback
        run_one(16'hFFFF, 13, 1, 1, 0, 1, 1, 20); // R8 return load, full list
        run_one(16'h40F0, 2, 0, 0, 1, 0, 1, 20);  // R7 user bank store, down pre
        run_one(16'h7F00, 1, 1, 1, 1, 1, 1, 40);  // R7 user bank load, up pre
        run_one(16'h8000, 0, 1, 1, 0, 0, 0, 50);  // R6 single PC load, plain
        run_one(16'h8000, 4, 0, 0, 0, 1, 1, 0);   // R6 PC store under user bit
        run_one(16'h8001, 9, 1, 0, 0, 1, 0, 60);  // R5 down post
        run_one(16'h0001, 6, 0, 1, 1, 1, 0, 0);   // R4 up pre, single
        run_one(16'hA5A5, 14, 1, 0, 1, 1, 0, 80); // R5 heavy stalls

        // Random instructions
        for (int t = 0; t < 60; t++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if ($urandom % 8 == 0) m = '0;
            run_one(m, int'($urandom % 16), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), int'($urandom % 60));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule